// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller that sits in front of a successive-approximation converter with its own sample-and-hold stage. Software starts a conversion by writing a start bit through a small write port. The sequencer first waits out a start delay. It then raises a sample strobe for a fixed window, drives a convert-active phase, and finally sets a sticky completion flag. A clock-select input picks one of two speeds. The variable part of the start delay comes from lining the start up with a free-running internal divider, so the exact delay depends on where in the divider cycle the write lands.

In single mode one channel is converted and the start bit drops by itself at the end. In scan mode the sequencer keeps going. Every conversion after the first runs on a fixed period, and the channel index steps from a first channel up to a last channel, then wraps back. The outputs are a sample enable, a convert-active level and a channel index, which drive a behavioural converter model. No data stream crosses this block, so every pin is a plain level or strobe with no handshake and no back-pressure.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, sample_en, conv_active, start_bit and done_flag are 0, and ch_idx is 0.
- R2: An internal divider counts clock cycles from 0 after reset and wraps with period P, where P = 8 when cks = 0 and P = 4 when cks = 1. Let p be the divider count (cycles since reset, modulo P) at the clock edge that accepts a start write. sample_en then first becomes 1 exactly D = Dmin + (P-1-p) edges later, with Dmin = 10 for cks = 0 and Dmin = 6 for cks = 1. This gives a delay of 10 to 17 cycles, or 6 to 9 cycles.
- R3: sample_en stays 1 for exactly 63 cycles (cks = 0) or 31 cycles (cks = 1). conv_active becomes 1 in the cycle right after the window, and the two are never 1 together.
- R4: In single mode the convert phase lasts 186 cycles (cks = 0) or 94 cycles (cks = 1), so start-to-end totals 259..266 or 131..134 cycles. At the end, done_flag becomes 1, start_bit returns to 0 and the sequencer goes idle.
- R5: In scan mode the first conversion follows the R2..R4 timing. Each later conversion is a sample window of the R3 length followed by a convert phase, and the two together last exactly 256 cycles (cks = 0) or 128 cycles (cks = 1). start_bit stays 1 throughout, and done_flag is set at the end of every conversion.
- R6: ch_idx takes ch_first when a start is accepted and holds steady through a conversion. In scan mode it advances by one after each conversion, and after ch_last it wraps to ch_first.
- R7: done_flag stays 1 until a write with reg_done = 0 clears it. If a completion and such a clear fall on the same edge, done_flag ends at 1.
- R8: A write with reg_start = 0 while busy returns the sequencer to idle on that edge: start_bit, sample_en and conv_active are all 0 afterwards, and done_flag is not set, even when the abort lands on the final convert cycle.
- R9: A write with reg_start = 1 while busy has no effect on the timing. cks, scan_mode, ch_first and ch_last are captured when a start is accepted, so later changes to them do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_start | input | 1 | Written start bit: 1 starts (if idle), 0 aborts |
| reg_done | input | 1 | Written completion bit: 0 clears done_flag, 1 keeps it |
| cks | input | 1 | Speed select: 0 slow timing, 1 fast timing |
| scan_mode | input | 1 | 0 single conversion, 1 repeating scan |
| ch_first | input | CHW | First channel (single-mode channel) |
| ch_last | input | CHW | Last channel of the scan loop |
| start_bit | output | 1 | Reads back the start bit; 1 while busy |
| done_flag | output | 1 | Sticky completion flag |
| sample_en | output | 1 | Sample-and-hold tracking window |
| conv_active | output | 1 | Convert phase active |
| ch_idx | output | CHW | Channel being converted |

## Verification
The bench uses the default parameters: the full 8-phase and 4-phase divider, the real window and conversion lengths, and four channels. With these values it can start a conversion on every divider phase at both speeds and compare each measured start delay with the arithmetic value. With four channels, a scan from channel 1 to channel 3 reaches the wrap back to the first channel within five conversions. The lengths are short enough to place writes on exact edges, so the tests cover a clear that coincides with a completion, an abort on the last convert cycle, and a redundant start in mid-window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_SAMPLE = 2'd2,
    PH_CONV   = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/adc_seq_div.sv
// Free-running phase divider; reports how many states remain to the next
// boundary of the selected period (2**DIVW slow, 2**(DIVW-1) fast).
module adc_seq_div #(
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cks,
  output logic [DIVW-1:0] rem
);
  logic [DIVW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    rem = ~cnt;
    if (cks) rem[DIVW-1] = 1'b0;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
// Phase sequencer: one shared down-counter times wait, sample and convert.
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int DIVW  = 3,
  parameter int DLY_S = 10,
  parameter int DLY_F = 6,
  parameter int SPL_S = 63,
  parameter int SPL_F = 31,
  parameter int CNV_S = 186,
  parameter int CNV_F = 94,
  parameter int PER_S = 256,
  parameter int PER_F = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            abort,
  input  logic            cks,
  input  logic            scan,
  input  logic [DIVW-1:0] rem,
  output seq_phase_e      phase,
  output logic            finish,
  output logic            scan_q
);
  localparam int CW = $clog2(PER_S + CNV_S + DLY_S + 1);

  logic          cks_q;
  logic          later;
  logic [CW-1:0] cnt;
  logic [CW-1:0] go_m1, spl_m1, cnv_m1;

  always_comb begin
    go_m1  = (cks ? CW'(DLY_F) : CW'(DLY_S)) + CW'(rem) - CW'(1);
    spl_m1 = cks_q ? CW'(SPL_F - 1) : CW'(SPL_S - 1);
    if (later) cnv_m1 = cks_q ? CW'(PER_F - SPL_F - 1) : CW'(PER_S - SPL_S - 1);
    else       cnv_m1 = cks_q ? CW'(CNV_F - 1) : CW'(CNV_S - 1);
    finish = (phase == PH_CONV) && (cnt == '0) && !abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      cks_q  <= 1'b0;
      scan_q <= 1'b0;
      later  <= 1'b0;
    end else if (abort) begin
      phase <= PH_IDLE;
      later <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase  <= PH_WAIT;
          cnt    <= go_m1;
          cks_q  <= cks;
          scan_q <= scan;
          later  <= 1'b0;
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            phase <= PH_SAMPLE;
            cnt   <= spl_m1;
          end else cnt <= cnt - 1'b1;
        end
        PH_SAMPLE: begin
          if (cnt == '0) begin
            phase <= PH_CONV;
            cnt   <= cnv_m1;
          end else cnt <= cnt - 1'b1;
        end
        PH_CONV: begin
          if (cnt == '0) begin
            if (scan_q) begin
              phase <= PH_SAMPLE;
              cnt   <= spl_m1;
              later <= 1'b1;
            end else phase <= PH_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chan.sv
// Channel pointer: loads the first channel on start, steps with wrap.
module adc_seq_chan #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [CHW-1:0] first,
  input  logic [CHW-1:0] last,
  output logic [CHW-1:0] idx
);
  logic [CHW-1:0] first_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      idx     <= first;
      first_q <= first;
      last_q  <= last;
    end else if (step) begin
      if (idx == last_q)                idx <= first_q;
      else if (idx == CHW'(NCH - 1))    idx <= '0;
      else                              idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DIVW  = 3,
  parameter int DLY_S = 10,
  parameter int DLY_F = 6,
  parameter int SPL_S = 63,
  parameter int SPL_F = 31,
  parameter int CNV_S = 186,
  parameter int CNV_F = 94,
  parameter int PER_S = 256,
  parameter int PER_F = 128,
  parameter int NCH   = 4,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_start,
  input  logic           reg_done,
  input  logic           cks,
  input  logic           scan_mode,
  input  logic [CHW-1:0] ch_first,
  input  logic [CHW-1:0] ch_last,
  output logic           start_bit,
  output logic           done_flag,
  output logic           sample_en,
  output logic           conv_active,
  output logic [CHW-1:0] ch_idx
);
  seq_phase_e      phase;
  logic            finish, scan_q, busy, go, abort;
  logic [DIVW-1:0] rem;

  assign busy  = (phase != PH_IDLE);
  assign go    = reg_wr && reg_start && !busy;
  assign abort = reg_wr && !reg_start && busy;

  adc_seq_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_n), .cks(cks), .rem(rem)
  );

  adc_seq_fsm #(
    .DIVW(DIVW), .DLY_S(DLY_S), .DLY_F(DLY_F), .SPL_S(SPL_S), .SPL_F(SPL_F),
    .CNV_S(CNV_S), .CNV_F(CNV_F), .PER_S(PER_S), .PER_F(PER_F)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .cks(cks),
    .scan(scan_mode), .rem(rem), .phase(phase), .finish(finish),
    .scan_q(scan_q)
  );

  adc_seq_chan #(.NCH(NCH), .CHW(CHW)) u_chan (
    .clk(clk), .rst_n(rst_n), .load(go), .step(finish && scan_q),
    .first(ch_first), .last(ch_last), .idx(ch_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     done_flag <= 1'b0;
    else if (finish)                done_flag <= 1'b1;
    else if (reg_wr && !reg_done)   done_flag <= 1'b0;
  end

  assign start_bit   = busy;
  assign sample_en   = (phase == PH_SAMPLE);
  assign conv_active = (phase == PH_CONV);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int SPL_MAX = 63,
  parameter int CHW     = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic           reg_start,
  input logic           start_bit,
  input logic           done_flag,
  input logic           sample_en,
  input logic           conv_active,
  input logic [CHW-1:0] ch_idx
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= 0;
    else if (sample_en) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= SPL_MAX);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_en, conv_active}));

  a_r3_conv_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) && start_bit |-> conv_active);

  a_r3_conv_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_active) |-> $past(sample_en));

  a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $fell(conv_active));

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && !reg_start && start_bit) |->
      !start_bit && !sample_en && !conv_active && !$rose(done_flag));

  a_r6_chan_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sample_en) || ($past(conv_active) && conv_active)) |-> $stable(ch_idx));
endmodule

bind adc_seq_top adc_seq_chk #(.SPL_MAX(SPL_S), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_start(reg_start),
  .start_bit(start_bit), .done_flag(done_flag), .sample_en(sample_en),
  .conv_active(conv_active), .ch_idx(ch_idx)
);

// File: tb/tb_adc_seq_top.sv
`timescale 1ns/1ps
module tb_adc_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_start = 1'b0, reg_done = 1'b1;
  logic       cks = 1'b0, scan_mode = 1'b0;
  logic [1:0] ch_first = '0, ch_last = '0;
  logic       start_bit, done_flag, sample_en, conv_active;
  logic [1:0] ch_idx;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         ended = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  adc_seq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_start(reg_start),
    .reg_done(reg_done), .cks(cks), .scan_mode(scan_mode),
    .ch_first(ch_first), .ch_last(ch_last), .start_bit(start_bit),
    .done_flag(done_flag), .sample_en(sample_en), .conv_active(conv_active),
    .ch_idx(ch_idx)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Single conversion launched at divider phase ph; ports changed afterwards (R9).
  task automatic run_single(input bit k, input int ph, input logic [1:0] first,
                            input bit busy_wr, input bit abort_end);
    int per_div = k ? 4 : 8;
    int dmin = k ? 6 : 10;
    int spl = k ? 31 : 63;
    int cnv = k ? 94 : 186;
    int r, d, s, c;
    do @(negedge clk); while ((cyc % per_div) != ph);
    cks = k; scan_mode = 0; ch_first = first; ch_last = first;
    r = per_div - 1 - ph;
    reg_wr = 1; reg_start = 1; reg_done = 1;
    @(negedge clk);
    reg_wr = 0;
    cks = ~k; scan_mode = 1; ch_first = ~first; ch_last = ~first;
    d = 0;
    while (!sample_en && d < 100) begin @(negedge clk); d++; end
    chk("R2 start delay", d == dmin + r, d, dmin + r);
    chk("R6 single channel", ch_idx == first, ch_idx, first);
    s = 0;
    while (sample_en && s < 200) begin
      if (busy_wr && s == 3) begin reg_wr = 1; reg_start = 1; reg_done = 1; end
      else reg_wr = 0;
      @(negedge clk); s++;
    end
    reg_wr = 0;
    chk("R3 sample window", s == spl, s, spl);
    chk("R3 convert follows", conv_active == 1'b1, conv_active, 1);
    c = 0;
    while (conv_active && c < 400) begin
      if (abort_end && c == cnv - 1) begin reg_wr = 1; reg_start = 0; reg_done = 1; end
      else reg_wr = 0;
      @(negedge clk); c++;
    end
    reg_wr = 0;
    if (abort_end) begin
      chk("R8 abort on last cycle done", done_flag == 1'b0, done_flag, 0);
      chk("R8 abort on last cycle idle", start_bit == 1'b0 && !sample_en, start_bit, 0);
    end else begin
      chk("R4 convert length", c == cnv, c, cnv);
      chk("R4 total", d + s + c == dmin + r + spl + cnv, d + s + c, dmin + r + spl + cnv);
      chk("R4 start bit clears", start_bit == 1'b0, start_bit, 0);
      repeat (4) @(negedge clk);
      chk("R7 done sticky", done_flag == 1'b1, done_flag, 1);
      reg_wr = 1; reg_start = 0; reg_done = 0;
      @(negedge clk);
      reg_wr = 0;
      chk("R7 done cleared", done_flag == 1'b0, done_flag, 0);
    end
  endtask

  task automatic run_scan(input bit k);
    int dmin = k ? 6 : 10;
    int spl = k ? 31 : 63;
    int cnv = k ? 94 : 186;
    int per = k ? 128 : 256;
    int per_div = k ? 4 : 8;
    int r, d, s, c, cexp;
    logic [1:0] exp_ch;
    @(negedge clk);
    cks = k; scan_mode = 1; ch_first = 2'd1; ch_last = 2'd3;
    r = per_div - 1 - (cyc % per_div);
    reg_wr = 1; reg_start = 1; reg_done = 1;
    @(negedge clk);
    reg_wr = 0; scan_mode = 0; ch_first = 2'd0; ch_last = 2'd0;
    d = 0;
    while (!sample_en && d < 100) begin @(negedge clk); d++; end
    chk("R5 first delay", d == dmin + r, d, dmin + r);
    for (int n = 1; n <= 5; n++) begin
      exp_ch = 2'd1 + 2'((n - 1) % 3);
      cexp = (n == 1) ? cnv : per - spl;
      chk("R6 scan channel", ch_idx == exp_ch, ch_idx, exp_ch);
      s = 0;
      while (sample_en && s < 200) begin
        if (n == 3 && s == 5) begin reg_wr = 1; reg_start = 1; reg_done = 0; end
        else reg_wr = 0;
        @(negedge clk); s++;
      end
      reg_wr = 0;
      chk("R3 scan sample window", s == spl, s, spl);
      if (n == 3) chk("R7 cleared during scan", done_flag == 1'b0, done_flag, 0);
      c = 0;
      while (conv_active && c < 400) begin
        if (n == 3 && c == cexp - 1) begin reg_wr = 1; reg_start = 1; reg_done = 0; end
        else reg_wr = 0;
        @(negedge clk); c++;
      end
      reg_wr = 0;
      if (n == 1) chk("R5 first convert", c == cnv, c, cnv);
      else        chk("R5 later period", s + c == per, s + c, per);
      if (n == 3) chk("R7 set beats clear", done_flag == 1'b1, done_flag, 1);
      else        chk("R5 done each conversion", done_flag == 1'b1, done_flag, 1);
      chk("R5 start bit held", start_bit == 1'b1, start_bit, 1);
      chk("R5 next sample direct", sample_en == 1'b1, sample_en, 1);
    end
    repeat (3) @(negedge clk);
    reg_wr = 1; reg_start = 0; reg_done = 1;
    @(negedge clk);
    reg_wr = 0;
    chk("R8 abort in sample", !start_bit && !sample_en && !conv_active, start_bit, 0);
    chk("R8 done untouched", done_flag == 1'b1, done_flag, 1);
    reg_wr = 1; reg_start = 0; reg_done = 0;
    @(negedge clk);
    reg_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", !sample_en && !conv_active && !start_bit && !done_flag,
        {sample_en, conv_active, start_bit, done_flag}, 0);
    chk("R1 reset channel", ch_idx == 2'd0, ch_idx, 0);
    for (int k = 0; k < 2; k++) begin
      for (int ph = 0; ph < (k ? 4 : 8); ph++) begin
        run_single(k[0], ph, 2'(ph), ph == 2, 1'b0);
      end
    end
    // R8 abort while waiting: nothing may follow
    @(negedge clk);
    cks = 0; scan_mode = 0; reg_wr = 1; reg_start = 1; reg_done = 1;
    @(negedge clk);
    reg_wr = 0;
    repeat (3) @(negedge clk);
    reg_wr = 1; reg_start = 0;
    @(negedge clk);
    reg_wr = 0;
    begin
      bit seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (sample_en || conv_active) seen = 1;
      end
      chk("R8 abort in wait", !seen && !start_bit && !done_flag, seen, 0);
    end
    run_single(1'b0, 5, 2'd3, 1'b0, 1'b1);
    run_single(1'b1, 1, 2'd2, 1'b0, 1'b1);
    run_scan(1'b0);
    run_scan(1'b1);
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end
endmodule